// File: doc/BRIEF.md
# Asynchronous Byte-Wide Static RAM Controller

This block lets a clocked requester on the chip read and write an external asynchronous static RAM holding 512K bytes. A request carries a direction bit, a 19-bit location and a write byte, and it is taken over a valid/ready handshake. The controller then drives the active-low select, output-enable and write-enable strobes, a registered address and a tri-stated data bus. Read bytes come back on a result port with a one-cycle valid strobe.

Every phase length is a count of clock cycles. It is derived from the clock period and from the selected speed grade: fast (55 ns) or slow (70 ns). Each requirement below gives the cycle counts for the defaults, which are a 10 ns clock and the fast grade.

Writes are controlled by the write-enable strobe. The data driver is on only around the write pulse. After each read the bus rests for a turnaround gap, which gives the memory's outputs time to float before the controller may drive them again.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and directly after synchronous reset, `sram_cs_n`, `sram_oe_n` and `sram_we_n` are 1, `req_ready` is 1 and `rd_valid` is 0.
- R2: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while idle, and a `req_valid` raised while busy has no effect on the bus or on the memory contents.
- R3: A read (`req_wr`=0) starts on the cycle after acceptance. It holds `sram_cs_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 for ceil(max(read cycle, access time)/period) cycles: 6 by default (55 ns), or 70 ns for the slow grade.
- R4: The byte on `sram_data` is captured at the edge that ends the read access. It appears on `rd_data` with `rd_valid`=1 for exactly one cycle, which is the first cycle after the access.
- R5: After a read, `sram_cs_n` and `sram_oe_n` stay 1 and `req_ready` stays 0 for ceil(float time/period) cycles: 2 by default (20 ns), or 25 ns for the slow grade. The controller cannot drive the bus before this gap ends.
- R6: A write (`req_wr`=1) starts with one setup cycle. In that cycle `sram_cs_n`=0, `sram_oe_n`=1 and `sram_we_n`=1, the address is valid, and the controller drives the write byte on `sram_data`.
- R7: `sram_we_n` is then 0 for max(ceil(pulse/period), ceil(data setup/period), ceil(write cycle/period)-2, 1) cycles, which is 4 by default. During this time address and data are held, and `sram_we_n`=0 only while `sram_cs_n`=0.
- R8: After the pulse comes one recovery cycle with `sram_we_n`=1 and `sram_cs_n`=0, the address unchanged and the data driver off. The controller is idle on the cycle after that.
- R9: The controller never drives `sram_data` while `sram_oe_n`=0.
- R10: `sram_addr` is stable for as long as `sram_cs_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte location |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-cycle strobe for returned read data |
| rd_data | output | 8 | Returned read byte |
| sram_addr | output | 19 | Memory address lines |
| sram_data | inout | 8 | Bidirectional memory data bus |
| sram_cs_n | output | 1 | Active-low chip select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |

## Verification
The case that is hardest to reach is a request that is held valid while the controller is busy. It must change nothing, even though it carries a different address and a write command. To reach it, the stimulus raises such a write on the first busy cycle of another transaction and drops it on the last busy cycle. The bench checks the pins cycle by cycle during that transaction, then reads the injected address back and expects its untouched default content. A write issued directly after a read exercises the bus turnaround, because the first cycle in which the controller may drive the bus follows the float gap with no slack.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int ADDR_W = 19;
    localparam int DATA_W = 8;

    typedef enum logic {
        GRADE_FAST = 1'b0,
        GRADE_SLOW = 1'b1
    } grade_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_GAP,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_REC
    } phase_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } req_t;

    // Nanoseconds to whole cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int read_ns(input grade_e g);
        return (g == GRADE_FAST) ? 55 : 70;
    endfunction

    function automatic int pulse_ns(input grade_e g);
        return (g == GRADE_FAST) ? 40 : 50;
    endfunction

    function automatic int dsetup_ns(input grade_e g);
        return (g == GRADE_FAST) ? 25 : 30;
    endfunction

    function automatic int wcycle_ns(input grade_e g);
        return (g == GRADE_FAST) ? 55 : 70;
    endfunction

    function automatic int float_ns(input grade_e g);
        return (g == GRADE_FAST) ? 20 : 25;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= bus_in;
            end
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int     CLK_PERIOD_NS = 10,
    parameter grade_e GRADE         = GRADE_FAST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    inout  wire  [DATA_W-1:0] sram_data,
    output logic              sram_cs_n,
    output logic              sram_oe_n,
    output logic              sram_we_n
);
    localparam int RD_CYC  = ns_to_cyc(read_ns(GRADE), CLK_PERIOD_NS);
    localparam int FLT_CYC = ns_to_cyc(float_ns(GRADE), CLK_PERIOD_NS);
    localparam int WP_CYC  = imax(imax(ns_to_cyc(pulse_ns(GRADE), CLK_PERIOD_NS),
                                       ns_to_cyc(dsetup_ns(GRADE), CLK_PERIOD_NS)),
                                  imax(ns_to_cyc(wcycle_ns(GRADE), CLK_PERIOD_NS) - 2, 1));
    localparam int MAX_CYC = imax(imax(RD_CYC, FLT_CYC), WP_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] FLT_LD = CNT_W'(FLT_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);

    phase_e           state_q, state_d;
    req_t             req_q;
    logic             t_load, t_done;
    logic [CNT_W-1:0] t_val;
    logic             capture;
    logic             drive_en;

    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    t_load  = 1'b1;
                    state_d = req_wr ? ST_WR_SETUP : ST_RD_ACC;
                    t_val   = req_wr ? '0 : RD_LD;
                end
            end
            ST_RD_ACC: begin
                if (t_done) begin
                    capture = 1'b1;
                    t_load  = 1'b1;
                    t_val   = FLT_LD;
                    state_d = ST_RD_GAP;
                end
            end
            ST_RD_GAP: begin
                if (t_done) state_d = ST_IDLE;
            end
            ST_WR_SETUP: begin
                t_load  = 1'b1;
                t_val   = WP_LD;
                state_d = ST_WR_PULSE;
            end
            ST_WR_PULSE: begin
                if (t_done) begin
                    t_load  = 1'b1;
                    state_d = ST_WR_REC;
                end
            end
            ST_WR_REC: begin
                if (t_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                req_q <= '{wr: req_wr, addr: req_addr, data: req_wdata};
            end
        end
    end

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    sram_read_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .bus_in   (sram_data),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign sram_cs_n = (state_q == ST_IDLE) || (state_q == ST_RD_GAP);
    assign sram_oe_n = (state_q != ST_RD_ACC);
    assign sram_we_n = (state_q != ST_WR_PULSE);
    assign drive_en  = (state_q == ST_WR_SETUP) || (state_q == ST_WR_PULSE);
    assign sram_addr = req_q.addr;
    assign sram_data = drive_en ? req_q.data : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_cs_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic              drive_en
);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sram_cs_n && sram_we_n && !drive_en));

    assert_rvalid_single_R4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    assert_rvalid_after_read_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> $rose(sram_oe_n));

    assert_we_within_cs_R7: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> !sram_cs_n);

    assert_driver_off_on_we_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (!drive_en && !sram_cs_n));

    assert_no_contention_R9: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> sram_oe_n);

    assert_addr_held_R10: assert property (@(posedge clk) disable iff (rst)
        (!sram_cs_n && !$past(sram_cs_n)) |-> $stable(sram_addr));
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(sram_ctrl_pkg::ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .sram_addr (sram_addr),
    .sram_cs_n (sram_cs_n),
    .sram_oe_n (sram_oe_n),
    .sram_we_n (sram_we_n),
    .drive_en  (drive_en)
);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;
    localparam int CLK_NS  = 10;
    localparam int E_RD    = (55 + CLK_NS - 1) / CLK_NS;
    localparam int E_FLT   = (20 + CLK_NS - 1) / CLK_NS;
    localparam int E_WP0   = (40 + CLK_NS - 1) / CLK_NS;
    localparam int E_WC    = (55 + CLK_NS - 1) / CLK_NS - 2;
    localparam int E_WP    = (E_WP0 > E_WC) ? E_WP0 : E_WC;
    localparam int WDOG    = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_wr = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic [18:0] sram_addr;
    wire  [7:0]  sram_data;
    logic        sram_cs_n, sram_oe_n, sram_we_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] mem_model [int];
    logic [7:0] exp_mem   [int];
    logic [7:0] mem_out;

    always #(CLK_NS/2) clk = ~clk;

    sram_async_ctrl #(.CLK_PERIOD_NS(CLK_NS)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .sram_addr(sram_addr), .sram_data(sram_data),
        .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
    );

    function automatic logic [7:0] dflt(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // Behavioural memory on the pins.
    always_comb begin
        if (mem_model.exists(int'(sram_addr))) mem_out = mem_model[int'(sram_addr)];
        else mem_out = dflt(sram_addr);
    end
    assign sram_data = (!sram_cs_n && !sram_oe_n && sram_we_n) ? mem_out : 8'bz;

    always @(negedge clk) begin
        if (!rst && !sram_cs_n && !sram_we_n) mem_model[int'(sram_addr)] = sram_data;
    end

    function automatic logic [7:0] exp_rd(input logic [18:0] a);
        if (exp_mem.exists(int'(a))) return exp_mem[int'(a)];
        return dflt(a);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Pin vector {cs_n, oe_n, we_n, req_ready, rd_valid}
    task automatic pins(input string req, input logic [4:0] exp, input logic [18:0] a);
        check(req, {27'd0, sram_cs_n, sram_oe_n, sram_we_n, req_ready, rd_valid}, {27'd0, exp});
        if (!exp[4]) check({req, " addr"}, {13'd0, sram_addr}, {13'd0, a});
    endtask

    task automatic do_op(input bit wr, input logic [18:0] a, input logic [7:0] d,
                         input bit inject, input logic [18:0] ia);
        int total;
        int k;
        @(negedge clk);
        check("R2 ready when idle", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        if (inject) begin
            req_wr = 1'b1; req_addr = ia; req_wdata = 8'hEE;
        end else begin
            req_valid = 1'b0;
        end
        total = wr ? (E_WP + 2) : (E_RD + E_FLT);
        for (k = 0; k < total; k++) begin
            if (!wr) begin
                if (k < E_RD) begin
                    pins("R3 read access", 5'b00100, a);
                end else begin
                    pins("R5 float gap", {4'b1110, (k == E_RD)}, a);
                    if (k == E_RD) check("R4 read data", {24'd0, rd_data}, {24'd0, exp_rd(a)});
                end
            end else begin
                if (k == 0) begin
                    pins("R6 write setup", 5'b01100, a);
                    check("R6 data driven", {24'd0, sram_data}, {24'd0, d});
                end else if (k <= E_WP) begin
                    pins("R7 write pulse", 5'b01000, a);
                    check("R7 data held", {24'd0, sram_data}, {24'd0, d});
                end else begin
                    pins("R8 recovery", 5'b01100, a);
                    check("R8 driver off", {24'd0, sram_data}, 32'h0000_00zz);
                end
            end
            if (k == total - 1) req_valid = 1'b0;
            @(negedge clk);
        end
        if (wr) exp_mem[int'(a)] = d;
        pins("R2 back to idle", 5'b11110, a);
    endtask

    initial begin
        int limit;
        limit = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WDOG) begin
                errors++;
                $display("FAIL watchdog expired at cycle %0d", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        pins("R1 reset state", 5'b11110, 19'd0);
        rst = 1'b0;
        @(negedge clk);
        pins("R1 after reset", 5'b11110, 19'd0);

        do_op(1'b1, 19'h00000, 8'hA5, 1'b0, '0);
        do_op(1'b1, 19'h7FFFF, 8'h5A, 1'b0, '0);
        do_op(1'b1, 19'h12345, 8'h0F, 1'b0, '0);
        do_op(1'b0, 19'h00000, 8'h00, 1'b0, '0);
        do_op(1'b0, 19'h7FFFF, 8'h00, 1'b0, '0);
        // Write straight after a read: turnaround gap (R5, R9).
        do_op(1'b0, 19'h12345, 8'h00, 1'b0, '0);
        do_op(1'b1, 19'h12345, 8'hC3, 1'b0, '0);
        do_op(1'b0, 19'h12345, 8'h00, 1'b0, '0);
        // Unwritten location returns memory default.
        do_op(1'b0, 19'h2AAAA, 8'h00, 1'b0, '0);
        // Held request while busy must be ignored (R2).
        do_op(1'b1, 19'h00100, 8'h77, 1'b1, 19'h4BCDE);
        do_op(1'b0, 19'h4BCDE, 8'h00, 1'b1, 19'h4BCDF);
        do_op(1'b0, 19'h4BCDF, 8'h00, 1'b0, '0);
        do_op(1'b0, 19'h00100, 8'h00, 1'b0, '0);
        check("R2 injected write absent", {24'd0, mem_model.exists(int'(19'h4BCDE)) ? 8'h01 : 8'h00}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule